// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is the bus side of a small serial memory that answers as a target on a two-wire I2C bus. It holds a 256-byte internal array. It oversamples SCL and SDA with the system clock and finds start, repeated start and stop conditions. It checks the device select byte against a fixed type code and three chip-enable pins, and it returns acknowledge bits. One address counter is kept across transactions.

A master sets the counter with a dummy write. That is a write select followed by two address bytes, high byte first; with the default size only the low byte is kept. After this the master either sends data bytes to store or issues a repeated start and reads. A read with no address load returns the byte at the counter. While the master acknowledges each byte, the target keeps streaming consecutive bytes. The counter wraps from the top address to zero. A write control input blocks stores only and has no effect on reads. The block never drives SDA high: the `sda_oe` output means "pull SDA low".

Top module: `i2c_mem_target`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0) and the address counter is 0, so a current address read returns the byte at address 0.
- R2: A select byte is accepted only when its upper seven bits, sent MSB first, are 1010 followed by `ce_i[2:0]`. Bit 0 is the read/write flag, with 1 meaning read. On a match the target pulls SDA low during the ninth clock. On a mismatch it does not acknowledge and drives nothing until the next start.
- R3: After a write select, the target acknowledges two address bytes (high, then low) and loads the counter from them.
- R4: After a repeated start and a read select, the target acknowledges and then shifts out the byte at the counter, MSB first, changing SDA only while SCL is low.
- R5: A read select with no preceding address load returns the byte at the current counter. The counter advances by one after every byte shifted out, including the last one.
- R6: If the master acknowledges a read byte (SDA low in the ninth clock), the next byte comes from the next address. If the master does not acknowledge, the target releases SDA and stays silent until a start.
- R7: During streaming the counter wraps from 0xFF to 0x00.
- R8: With `wc_i` low, each data byte that follows the address bytes is acknowledged, stored at the counter, and the counter advances.
- R9: With `wc_i` high, data bytes are not acknowledged, memory and counter stay unchanged, and reads work normally.
- R10: A start or stop is recognised in any state. A start restarts select-byte reception from bit 0. A stop returns the target to idle and leaves the counter as it was.
- R11: `sda_oe` changes only in response to a falling SCL edge, a start or a stop. It never changes while SCL is high in the middle of a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired bus value) |
| ce_i | input | 3 | Chip-enable bits matched in the select byte |
| wc_i | input | 1 | Write control, high blocks stores |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
The main function is exercised by a vector table of address/data pairs. Each pair is stored and then read back through a random read. The pairs include the lowest and highest addresses and the all-zero and all-one bytes, so an address or bit-order error shows up as a wrong value at a known location. Directed sequences then contrast the different read modes. A current read after a random read tells counter advance apart from counter reload. A sequential stream across 0xFE..0x01 tells wrap apart from saturation. A mismatched chip-enable select tells matching apart from acceptance of any code. Writes with the write control raised tell gating of stores apart from gating of reads. A stop between address bytes and a start in the middle of a byte show that bus conditions abort the transfer at any point.

// File: rtl/i2c_mem_target.sv
module i2c_mem_target #(
  parameter int          AW       = 8,
  parameter logic [3:0]  DEV_TYPE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] ce_i,
  input  logic       wc_i,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, DEV, AHI, ALO, WR, RD} st_t;

  st_t          st;
  logic [2:0]   scl_p, sda_p;
  logic [3:0]   cnt;
  logic [7:0]   sr, ahi, tx, rdata;
  logic [AW-1:0] addr;
  logic         rw, mack;
  logic [7:0]   mem [DEPTH];

  wire scl_s = scl_p[1], scl_q = scl_p[2];
  wire sda_s = sda_p[1], sda_q = sda_p[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire mem_we   = (st == WR) && scl_fall && (cnt == 4'd8) && !wc_i;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr] <= sr;
    rdata <= mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; sr <= '0; ahi <= '0; tx <= '0;
      addr <= '0; rw <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
    end else if (start) begin
      st <= DEV; cnt <= '0; sda_oe <= 1'b0;
    end else if (stop) begin
      st <= IDLE; cnt <= '0; sda_oe <= 1'b0;
    end else if (st != IDLE) begin
      if (scl_rise) begin
        if (cnt < 4'd8) begin
          cnt <= cnt + 4'd1;
          sr  <= {sr[6:0], sda_s};
        end else if (cnt == 4'd8) begin
          cnt  <= 4'd9;
          mack <= ~sda_s;
        end
      end else if (scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            DEV: if (sr[7:1] == {DEV_TYPE, ce_i}) begin
                   sda_oe <= 1'b1; rw <= sr[0];
                 end else st <= IDLE;
            AHI: begin sda_oe <= 1'b1; ahi <= sr; end
            ALO: begin sda_oe <= 1'b1; addr <= AW'({ahi, sr}); end
            WR:  if (!wc_i) begin sda_oe <= 1'b1; addr <= addr + 1'b1; end
            RD:  begin sda_oe <= 1'b0; addr <= addr + 1'b1; end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          sda_oe <= 1'b0;
          case (st)
            DEV: if (rw) begin
                   st <= RD; tx <= rdata; sda_oe <= ~rdata[7];
                 end else st <= AHI;
            AHI: st <= ALO;
            ALO: st <= WR;
            WR:  if (!sda_oe) st <= IDLE;
            RD:  if (mack) begin
                   tx <= rdata; sda_oe <= ~rdata[7];
                 end else st <= IDLE;
            default: ;
          endcase
        end else if (st == RD) begin
          sda_oe <= ~tx[3'd7 - cnt[2:0]];
        end
      end
    end
  end

  assert_start_rearm_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (st == DEV && cnt == 4'd0));

  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (st == IDLE && !sda_oe));

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !sda_oe);

  assert_sda_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start || stop));

  assert_counter_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RD && scl_fall && cnt == 4'd8) |=> (AW'(addr - $past(addr)) == AW'(1)));

  assert_wc_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WR && scl_fall && cnt == 4'd8 && wc_i) |=> (!sda_oe && $stable(addr)));
endmodule

// File: tb/sim_i2c_mem_target.sv
module sim_i2c_mem_target;
  localparam int H = 8;
  localparam logic [2:0] CE = 3'b101;
  localparam logic [7:0] WSEL = {4'b1010, CE, 1'b0};
  localparam logic [7:0] RSEL = {4'b1010, CE, 1'b1};
  localparam logic [15:0] VEC [8] = '{16'h00_3C, 16'h01_A5, 16'h02_00, 16'h80_FF,
                                      16'hFE_5A, 16'hFF_C3, 16'h10_81, 16'h11_7E};

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1, wc = 0, prev_oe = 0;
  logic sda_oe;
  int n_chk = 0, n_fail = 0, viol = 0;
  wire sda_bus = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_mem_target u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
                     .ce_i(CE), .wc_i(wc), .sda_oe(sda_oe));

  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe !== prev_oe) viol++;
    prev_oe <= sda_oe;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; wt(H); scl_m = 1; wt(H); sda_m = 0; wt(H); scl_m = 0; wt(2); endtask
  task automatic bus_stop(); sda_m = 0; wt(H); scl_m = 1; wt(H); sda_m = 1; wt(H); endtask
  task automatic put_bit(input logic b); sda_m = b; wt(H); scl_m = 1; wt(H); scl_m = 0; wt(2); endtask
  task automatic get_bit(output logic b);
    sda_m = 1; wt(H); scl_m = 1; wt(H/2); b = sda_bus; wt(H/2); scl_m = 0; wt(2);
  endtask
  task automatic put_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b); ack = !b;
  endtask
  task automatic get_byte(input logic ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin get_bit(b); d[i] = b; end
    put_bit(!ack);
  endtask
  task automatic addr_load(input logic [7:0] a, output logic ok);
    logic a0, a1, a2;
    bus_start(); put_byte(WSEL, a0); put_byte(8'h00, a1); put_byte(a, a2);
    ok = a0 & a1 & a2;
  endtask
  task automatic write_byte(input logic [7:0] a, input logic [7:0] d, output logic ok, output logic dack);
    addr_load(a, ok); put_byte(d, dack); bus_stop();
  endtask
  task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k, s;
    addr_load(a, k); bus_start(); put_byte(RSEL, s); get_byte(1'b0, d); bus_stop();
    ok = k & s;
  endtask
  task automatic cur_read(output logic [7:0] d, output logic ok);
    bus_start(); put_byte(RSEL, ok); get_byte(1'b0, d); bus_stop();
  endtask

  initial begin
    logic [7:0] d;
    logic ok, ack;
    wt(5);
    chk("R1 sda released in reset", sda_oe, 0);
    rst_n = 1; wt(5);
    chk("R1 sda released after reset", sda_oe, 0);

    for (int i = 0; i < 8; i++) begin
      write_byte(VEC[i][15:8], VEC[i][7:0], ok, ack);
      chk("R3 address bytes acked", ok, 1);
      chk("R8 data byte acked", ack, 1);
      rand_read(VEC[i][15:8], d, ok);
      chk("R2 read select acked", ok, 1);
      chk("R4 random read data", d, VEC[i][7:0]);
    end

    write_byte(8'h10, 8'h81, ok, ack);
    cur_read(d, ok);
    chk("R8 counter advanced after store", d, 8'h7E);
    rand_read(8'h10, d, ok);
    cur_read(d, ok);
    chk("R5 current read after random read", d, 8'h7E);

    addr_load(8'hFE, ok);
    bus_start(); put_byte(RSEL, ack);
    get_byte(1'b1, d); chk("R6 stream byte at FE", d, 8'h5A);
    get_byte(1'b1, d); chk("R6 stream byte at FF", d, 8'hC3);
    get_byte(1'b1, d); chk("R7 wrap to 00", d, 8'h3C);
    get_byte(1'b0, d); chk("R6 stream byte at 01", d, 8'hA5);
    chk("R6 released after master nack", sda_oe, 0);
    bus_stop();
    cur_read(d, ok);
    chk("R5 counter advanced past last byte", d, 8'h00);

    bus_start(); put_byte({4'b1010, ~CE, 1'b1}, ack);
    chk("R2 mismatch not acked", ack, 0);
    get_byte(1'b0, d);
    chk("R2 no drive after mismatch", d, 8'hFF);
    bus_stop();

    wc = 1;
    write_byte(8'h10, 8'h99, ok, ack);
    chk("R9 address still acked with wc high", ok, 1);
    chk("R9 data not acked with wc high", ack, 0);
    rand_read(8'h10, d, ok);
    chk("R9 memory unchanged and read works", d, 8'h81);
    wc = 0;

    rand_read(8'h00, d, ok);
    bus_start(); put_byte(WSEL, ack); put_byte(8'h00, ack); bus_stop();
    cur_read(d, ok);
    chk("R10 stop mid address keeps counter", d, 8'hA5);
    bus_start(); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start(); put_byte(RSEL, ack);
    chk("R10 start mid byte restarts select", ack, 1);
    get_byte(1'b0, d); bus_stop();
    chk("R10 read after restart", d, 8'h00);

    wt(4); rst_n = 0; wt(4); rst_n = 1; wt(4);
    chk("R1 sda released after second reset", sda_oe, 0);
    cur_read(d, ok);
    chk("R1 counter zero after reset", d, 8'h3C);

    chk("R11 no sda change while scl high", viol, 0);
    summary();
  end
endmodule